// File: doc/BRIEF.md
# Multi-ADC Strip Readout Sequencer

This block drives the digitization of one queued capacitor block at a time. Six slow converters share the 96 strips of a cathode board. The sequencer hands each converter its strip and capacitor address in turn, so that their conversions overlap. It then merges the 13-bit results into a single word stream that goes to the data-acquisition motherboard. An event enters through a small queue port that gives a block number and two trigger flags. The block digitizes the event only when both the level-1 accept flag and the local-trigger match flag are set. Every digitized event produces 768 words (8 samples × 96 strips), followed by a one-cycle completion pulse that returns the block number to the buffer manager.

Conversions are spread round-robin across the converters. Consecutive output words therefore always come from different converters. With a conversion latency of up to about six word slots, a new word can leave every clock. Downstream back-pressure propagates back to the converter start strobes, and no word is lost.

Top module: `strip_rdo_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `word_valid_o`, `adc_start_o`, `evt_done_o` and `evt_pop_o` (with no event offered) are all low.
- R2: At most one converter start is raised per cycle. Converter k serves the strips whose index modulo 6 is k. A start on converter k carries local channel `adc_chan_o` = strip/6 and capacitor address `adc_cap_o` = {block number, sample index}, with the sample index in the low 3 bits.
- R3: A digitized event produces exactly 768 words. Their order has the sample index (0..7) as the outer loop and the strip index (0..95) as the inner loop.
- R4: Each output word is the 13-bit result of the matching conversion, passed unchanged. Bits 11:0 hold the charge and bit 12 holds the overflow flag.
- R5: `word_sof_o` is high only on word 0 of an event, and `word_eof_o` is high only on word 767.
- R6: While `word_valid_o` is high and `word_ready_i` is low, the word and its markers stay stable. No word is dropped or repeated under any ready pattern.
- R7: An offered event that lacks either trigger flag is popped without any converter start, any output word or any completion pulse.
- R8: `evt_done_o` pulses for one cycle in the cycle after the last word is accepted, with `evt_done_blk_o` equal to that event's block number. There is exactly one pulse per digitized event.
- R9: Events are processed in queue order. A new event is popped only once the previous digitized event has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one output word slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | Queue head holds an event |
| evt_blk_i | input | BLK_W | Capacitor block number of the head event |
| evt_l1a_i | input | 1 | Head event has a level-1 accept |
| evt_lct_i | input | 1 | Head event has a matching local trigger |
| evt_pop_o | output | 1 | Head event is consumed this cycle |
| adc_start_o | output | N_ADC | One-hot conversion start, one bit per converter |
| adc_chan_o | output | CHAN_W | Local strip channel for the started converter |
| adc_cap_o | output | BLK_W+SMP_W | Capacitor address {block, sample} for the started converter |
| adc_done_i | input | N_ADC | Conversion-complete strobes |
| adc_data_i | input | N_ADC*DATA_W | Results, converter k in bits k*DATA_W and up |
| word_o | output | DATA_W | Output strip word |
| word_valid_o | output | 1 | Output word valid |
| word_sof_o | output | 1 | First word of an event |
| word_eof_o | output | 1 | Last word of an event |
| word_ready_i | input | 1 | Downstream accepts the word |
| evt_done_o | output | 1 | Event digitization complete, one cycle |
| evt_done_blk_o | output | BLK_W | Block number released with the completion pulse |

## Verification
The assertions rely on these input rules. A converter raises its done strobe exactly once per start, after at least one cycle, and presents valid data in the same cycle. The queue holds its head fields steady until the pop. Ready may follow any pattern. The bench meets these rules with a converter model that arms a fixed per-converter latency on each start and strobes once, and with a queue driver that releases an event only after it sees the pop. The bench also drives ready as always high, as random, and as a periodic one-in-three gap, so that the stall properties are exercised both under steady pressure and in bursts.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_CONV = 2'd1,
    SL_FULL = 2'd2
  } slot_st_e;
endpackage

// File: rtl/rdo_word_cnt.sv
// Word position walker: converter fastest, local channel next, sample slowest.
module rdo_word_cnt #(
  parameter int N_ADC          = 6,
  parameter int STRIPS_PER_ADC = 16,
  parameter int N_SAMPLES      = 8,
  localparam int ADC_W  = $clog2(N_ADC),
  localparam int CHAN_W = $clog2(STRIPS_PER_ADC),
  localparam int SMP_W  = $clog2(N_SAMPLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADC_W-1:0]  adc_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [SMP_W-1:0]  smp_o,
  output logic              first_o,
  output logic              last_o
);
  logic [ADC_W-1:0]  adc_q;
  logic [CHAN_W-1:0] chan_q;
  logic [SMP_W-1:0]  smp_q;
  logic adc_wrap, chan_wrap, smp_wrap;

  assign adc_wrap  = (adc_q  == ADC_W'(N_ADC - 1));
  assign chan_wrap = (chan_q == CHAN_W'(STRIPS_PER_ADC - 1));
  assign smp_wrap  = (smp_q  == SMP_W'(N_SAMPLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adc_q  <= '0;
      chan_q <= '0;
      smp_q  <= '0;
    end else if (adv_i) begin
      if (adc_wrap) begin
        adc_q <= '0;
        if (chan_wrap) begin
          chan_q <= '0;
          smp_q  <= smp_wrap ? '0 : smp_q + 1'b1;
        end else begin
          chan_q <= chan_q + 1'b1;
        end
      end else begin
        adc_q <= adc_q + 1'b1;
      end
    end
  end

  assign adc_o   = adc_q;
  assign chan_o  = chan_q;
  assign smp_o   = smp_q;
  assign first_o = (adc_q == '0) && (chan_q == '0) && (smp_q == '0);
  assign last_o  = adc_wrap && chan_wrap && smp_wrap;

  a_r3_pos_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_q <= ADC_W'(N_ADC - 1));
endmodule

// File: rtl/rdo_adc_slot.sv
// Tracks one converter: idle, converting, or holding an unread result.
module rdo_adc_slot
  import rdo_pkg::*;
#(
  parameter int DATA_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              free_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  slot_st_e          st_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SL_IDLE;
      data_q <= '0;
    end else begin
      unique case (st_q)
        SL_IDLE: if (start_i) st_q <= SL_CONV;
        SL_CONV: if (done_i) begin
          st_q   <= SL_FULL;
          data_q <= data_i;
        end
        SL_FULL: if (take_i) st_q <= start_i ? SL_CONV : SL_IDLE;
        default: st_q <= SL_IDLE;
      endcase
    end
  end

  // a result read this cycle frees the converter for a back-to-back start
  assign free_o = (st_q == SL_IDLE) || ((st_q == SL_FULL) && take_i);
  assign full_o = (st_q == SL_FULL);
  assign data_o = data_q;

  a_r6_slot_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SL_FULL && !take_i) |=> (st_q == SL_FULL && $stable(data_q)));
  a_r3_take_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> st_q == SL_FULL);
endmodule

// File: rtl/rdo_out_stage.sv
// Registered output word with valid/ready hold.
module rdo_out_stage #(
  parameter int DATA_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              ready_i,
  output logic              can_load_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sof_o,
  output logic              eof_o
);
  logic              valid_q, sof_q, eof_q;
  logic [DATA_W-1:0] data_q;

  assign can_load_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
    end else if (can_load_o) begin
      valid_q <= load_i;
      if (load_i) begin
        data_q <= data_i;
        sof_q  <= sof_i;
        eof_q  <= eof_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign sof_o   = valid_q && sof_q;
  assign eof_o   = valid_q && eof_q;

  a_r6_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q) && $stable(sof_q) && $stable(eof_q)));
  a_r5_marks_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sof_o && eof_o));
endmodule

// File: rtl/strip_rdo_seq.sv
module strip_rdo_seq #(
  parameter int N_ADC          = 6,
  parameter int STRIPS_PER_ADC = 16,
  parameter int N_SAMPLES      = 8,
  parameter int DATA_W         = 13,
  parameter int BLK_W          = 4,
  localparam int ADC_W  = $clog2(N_ADC),
  localparam int CHAN_W = $clog2(STRIPS_PER_ADC),
  localparam int SMP_W  = $clog2(N_SAMPLES),
  localparam int CAP_W  = BLK_W + SMP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    evt_valid_i,
  input  logic [BLK_W-1:0]        evt_blk_i,
  input  logic                    evt_l1a_i,
  input  logic                    evt_lct_i,
  output logic                    evt_pop_o,
  output logic [N_ADC-1:0]        adc_start_o,
  output logic [CHAN_W-1:0]       adc_chan_o,
  output logic [CAP_W-1:0]        adc_cap_o,
  input  logic [N_ADC-1:0]        adc_done_i,
  input  logic [N_ADC*DATA_W-1:0] adc_data_i,
  output logic [DATA_W-1:0]       word_o,
  output logic                    word_valid_o,
  output logic                    word_sof_o,
  output logic                    word_eof_o,
  input  logic                    word_ready_i,
  output logic                    evt_done_o,
  output logic [BLK_W-1:0]        evt_done_blk_o
);
  logic             busy_q, iss_all_q, done_q;
  logic [BLK_W-1:0] blk_q, done_blk_q;

  logic              evt_take, can_issue, coll_load, can_load, fin;
  logic [ADC_W-1:0]  iss_adc, coll_adc;
  logic [CHAN_W-1:0] iss_chan, coll_chan;
  logic [SMP_W-1:0]  iss_smp, coll_smp;
  logic              iss_first, iss_last, coll_first, coll_last;
  logic [N_ADC-1:0]  slot_free, slot_full, slot_take;
  logic [DATA_W-1:0] slot_data [N_ADC];

  assign evt_pop_o = !busy_q && evt_valid_i;
  assign evt_take  = evt_pop_o && evt_l1a_i && evt_lct_i;

  // issue side
  rdo_word_cnt #(
    .N_ADC(N_ADC), .STRIPS_PER_ADC(STRIPS_PER_ADC), .N_SAMPLES(N_SAMPLES)
  ) u_iss_cnt (
    .clk_i, .rst_ni, .adv_i(can_issue),
    .adc_o(iss_adc), .chan_o(iss_chan), .smp_o(iss_smp),
    .first_o(iss_first), .last_o(iss_last)
  );

  assign can_issue   = busy_q && !iss_all_q && slot_free[iss_adc];
  assign adc_start_o = can_issue ? (N_ADC'(1) << iss_adc) : '0;
  assign adc_chan_o  = iss_chan;
  assign adc_cap_o   = {blk_q, iss_smp};

  // per-converter result slots
  for (genvar k = 0; k < N_ADC; k++) begin : g_slot
    rdo_adc_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i, .rst_ni,
      .start_i(adc_start_o[k]),
      .done_i (adc_done_i[k]),
      .data_i (adc_data_i[k*DATA_W +: DATA_W]),
      .take_i (slot_take[k]),
      .free_o (slot_free[k]),
      .full_o (slot_full[k]),
      .data_o (slot_data[k])
    );
  end

  // collect side
  rdo_word_cnt #(
    .N_ADC(N_ADC), .STRIPS_PER_ADC(STRIPS_PER_ADC), .N_SAMPLES(N_SAMPLES)
  ) u_coll_cnt (
    .clk_i, .rst_ni, .adv_i(coll_load),
    .adc_o(coll_adc), .chan_o(coll_chan), .smp_o(coll_smp),
    .first_o(coll_first), .last_o(coll_last)
  );

  assign coll_load = busy_q && slot_full[coll_adc] && can_load;
  assign slot_take = coll_load ? (N_ADC'(1) << coll_adc) : '0;

  rdo_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni,
    .load_i    (coll_load),
    .data_i    (slot_data[coll_adc]),
    .sof_i     (coll_first),
    .eof_i     (coll_last),
    .ready_i   (word_ready_i),
    .can_load_o(can_load),
    .valid_o   (word_valid_o),
    .data_o    (word_o),
    .sof_o     (word_sof_o),
    .eof_o     (word_eof_o)
  );

  assign fin = word_valid_o && word_ready_i && word_eof_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      iss_all_q  <= 1'b0;
      blk_q      <= '0;
      done_q     <= 1'b0;
      done_blk_q <= '0;
    end else begin
      if (evt_take) begin
        busy_q <= 1'b1;
        blk_q  <= evt_blk_i;
      end else if (fin) begin
        busy_q <= 1'b0;
      end
      if (fin) iss_all_q <= 1'b0;
      else if (can_issue && iss_last) iss_all_q <= 1'b1;
      done_q <= fin;
      if (fin) done_blk_q <= blk_q;
    end
  end

  assign evt_done_o     = done_q;
  assign evt_done_blk_o = done_blk_q;

  a_r2_one_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adc_start_o));
  a_r8_done_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_done_o |-> $past(word_valid_o && word_ready_i && word_eof_o));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_done_o |=> !evt_done_o);
  a_r9_no_pop_midevent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !word_eof_o) |-> !evt_pop_o);
  a_r7_idle_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_pop_o && !(evt_l1a_i && evt_lct_i)) |=> adc_start_o == '0);
endmodule

// File: tb/strip_rdo_seq_tb.sv
`timescale 1ns/1ps
module strip_rdo_seq_tb;
  localparam int NA = 6, SPA = 16, NS = 8, DW = 13, BW = 4;
  localparam int NSTRIP = NA * SPA;
  localparam int NWORD  = NSTRIP * NS;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic evt_valid_i = 1'b0;
  logic [BW-1:0] evt_blk_i = '0;
  logic evt_l1a_i = 1'b0, evt_lct_i = 1'b0;
  logic evt_pop_o;
  logic [NA-1:0] adc_start_o;
  logic [3:0] adc_chan_o;
  logic [BW+2:0] adc_cap_o;
  logic [NA-1:0] adc_done_i = '0;
  logic [NA*DW-1:0] adc_data_i = '0;
  logic [DW-1:0] word_o;
  logic word_valid_o, word_sof_o, word_eof_o;
  logic word_ready_i = 1'b1;
  logic evt_done_o;
  logic [BW-1:0] evt_done_blk_o;

  always #4 clk_i = ~clk_i;

  strip_rdo_seq u_dut (.*);

  int n_chk = 0, n_bad = 0;
  int rmode = 0, cyc = 0;
  int words_total = 0, starts_seen = 0, done_cnt = 0, n_exp = 0;
  int exp_list [16];
  int cnt [NA];
  logic [DW-1:0] res [NA];
  bit prev_stall = 0, prev_eof_acc = 0;
  logic [DW-1:0] prev_word;
  bit prev_sof, prev_eof;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fval(input int blk, input int smp, input int strip);
    logic [11:0] q;
    q = 12'((blk * 331 + smp * 97 + strip * 13 + 5) & 12'hFFF);
    return {((strip + smp + blk) % 5 == 0), q};
  endfunction

  // stimulus and observation, away from the rising edge
  always @(negedge clk_i) begin
    cyc++;
    case (rmode)
      0: word_ready_i = 1'b1;
      1: word_ready_i = 1'($urandom % 2);
      default: word_ready_i = (cyc % 3 != 0);
    endcase
    for (int a = 0; a < NA; a++) begin
      adc_done_i[a] = 1'b0;
      if (cnt[a] > 0) begin
        cnt[a]--;
        if (cnt[a] == 0) begin
          adc_done_i[a] = 1'b1;
          adc_data_i[a*DW +: DW] = res[a];
        end
      end
    end
    #1;
    if (rst_ni) begin
      // R6: held word under back-pressure
      if (prev_stall)
        chk(word_valid_o && word_o == prev_word && word_sof_o == prev_sof && word_eof_o == prev_eof,
            "R6 hold", int'(word_o), int'(prev_word));
      for (int a = 0; a < NA; a++) if (adc_start_o[a]) begin
        int ev, strip;
        starts_seen++;
        ev = (n_exp > 0) ? exp_list[done_cnt] : -1;
        strip = int'(adc_chan_o) * NA + a;
        chk(int'(adc_cap_o[BW+2:3]) == ev && strip < NSTRIP, "R2 cap addr", int'(adc_cap_o[BW+2:3]), ev);
        chk($countones(adc_start_o) == 1, "R2 one start", $countones(adc_start_o), 1);
        cnt[a] = 4 + (a % 3);
        res[a] = fval(int'(adc_cap_o[BW+2:3]), int'(adc_cap_o[2:0]), strip);
      end
      if (evt_done_o) begin
        chk(prev_eof_acc, "R8 done timing", 0, 1);
        chk(int'(evt_done_blk_o) == exp_list[done_cnt], "R8 done blk", int'(evt_done_blk_o), exp_list[done_cnt]);
        done_cnt++;
      end
      prev_eof_acc = 0;
      if (word_valid_o && word_ready_i) begin
        int k, blk;
        k = words_total % NWORD;
        blk = exp_list[words_total / NWORD];
        chk(word_o == fval(blk, k / NSTRIP, k % NSTRIP), "R3 R4 word", int'(word_o),
            int'(fval(blk, k / NSTRIP, k % NSTRIP)));
        chk(word_sof_o == (k == 0) && word_eof_o == (k == NWORD - 1), "R5 marks",
            {word_sof_o, word_eof_o}, {(k == 0), (k == NWORD - 1)});
        prev_eof_acc = word_eof_o;
        words_total++;
      end
    end
    prev_stall = word_valid_o && !word_ready_i;
    prev_word  = word_o;
    prev_sof   = word_sof_o;
    prev_eof   = word_eof_o;
  end

  task automatic push_evt(input int blk, input bit l1a, input bit lct);
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_blk_i = BW'(blk); evt_l1a_i = l1a; evt_lct_i = lct;
    #2;
    while (!evt_pop_o) begin
      @(negedge clk_i); #2;
    end
    if (l1a && lct) exp_list[n_exp++] = blk;
    @(posedge clk_i); #1;
    evt_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (done_cnt < n_exp && guard < 20000) begin
      @(negedge clk_i); guard++;
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!word_valid_o && adc_start_o == 0 && !evt_done_o && !evt_pop_o, "R1 in reset", 1, 0);
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    chk(!word_valid_o && adc_start_o == 0 && !evt_done_o && !evt_pop_o, "R1 after reset", 1, 0);
  endtask

  task automatic t_single(input int blk, input int mode);
    rmode = mode;
    push_evt(blk, 1, 1);
    wait_idle();
    chk(words_total == n_exp * NWORD, "R3 word count", words_total, n_exp * NWORD);
    chk(done_cnt == n_exp, "R8 done count", done_cnt, n_exp);
  endtask

  task automatic t_discard();
    int s0, w0, d0;
    rmode = 0;
    s0 = starts_seen; w0 = words_total; d0 = done_cnt;
    push_evt(5, 1, 0);
    push_evt(6, 0, 1);
    push_evt(7, 0, 0);
    repeat (30) @(negedge clk_i);
    chk(starts_seen == s0, "R7 no start", starts_seen, s0);
    chk(words_total == w0, "R7 no word", words_total, w0);
    chk(done_cnt == d0, "R7 no done", done_cnt, d0);
  endtask

  task automatic t_back2back(input int b0, input int b1, input int mode);
    int d0;
    rmode = mode;
    d0 = done_cnt;
    push_evt(b0, 1, 1);
    push_evt(b1, 1, 1);
    // second pop returns only after the first event completed
    chk(done_cnt == d0 + 1, "R9 pop after done", done_cnt, d0 + 1);
    wait_idle();
    chk(words_total == n_exp * NWORD, "R9 total words", words_total, n_exp * NWORD);
    chk(done_cnt == n_exp, "R9 done order", done_cnt, n_exp);
  endtask

  initial begin
    for (int a = 0; a < NA; a++) begin cnt[a] = 0; res[a] = '0; end
    fork
      begin
        t_reset();
        t_single(3, 0);
        t_single(11, 1);
        t_discard();
        t_back2back(0, 15, 2);
        t_single(9, 1);
        repeat (5) @(negedge clk_i);
      end
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", done_cnt, n_exp);
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule